// File: doc/BRIEF.md
# Gated-clock parallel-load shift register

This block is an eight-stage shift register with parallel capture and a single serial output. A low level on the load control copies eight parallel bits into the stages. While that control is high, each rising edge of the gated device clock moves every stage one place toward the last stage, and the first stage takes the serial input. The last stage is driven out in true and complemented form.

The device clock is formed from two pins combined with NOR-style gating. A high level on either pin holds the gated clock in its inhibited state, so each pin can serve as the clock or as a clock-inhibit control. The whole block runs from a single system clock. The two pins are treated as asynchronous levels: each passes through a two-flop synchronizer, and rising edges of the gated combination are found by comparing the current synchronized value with the value from the previous cycle. The load control, the serial input and the parallel inputs are synchronous to the system clock.

Top module: `gated_piso_shift`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0, so `q_last`=0 and `q_last_n`=1. It also puts the edge history into the inhibited state, so a pin that is already high when reset ends does not cause a shift.
- R2: When `load_n` is 0 at a system clock edge, the stages take `par_in` at that edge, whatever the clock pins are doing. `par_in[0]` is the first stage and `par_in[7]` is the last stage, which drives `q_last`.
- R3: A gated-clock rising edge that is acted on while `load_n` is 0 causes no shift. The register holds the loaded value.
- R4: While either clock pin is high, changes on the other pin cause no shift.
- R5: With `load_n` at 1, a 0-to-1 change of the gated clock (`clk_pin_a` OR `clk_pin_b`) causes exactly one shift. The shift takes effect at the third rising system clock edge after the pin change.
- R6: On a shift, the first stage takes `ser_in` as sampled at the shift edge, and each other stage takes the previous value of the stage before it. The loaded bits leave on `q_last` in the order `par_in[7]`, `par_in[6]`, ..., `par_in[0]`.
- R7: When there is neither a load nor a shift, all stages keep their values.
- R8: `q_last_n` is always the inverse of `q_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_pin_a | input | 1 | Device clock pin A, asynchronous (high inhibits pin B) |
| clk_pin_b | input | 1 | Device clock pin B, asynchronous (high inhibits pin A) |
| load_n | input | 1 | Parallel load control, active low, overrides shifting |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | 8 | Parallel data, bit 0 is the first stage |
| q_last | output | 1 | Last stage, registered |
| q_last_n | output | 1 | Complement of the last stage, registered |

## Verification
A parallel load is visible on the outputs one system cycle after the edge that samples `load_n` low. A pin change is visible only after three rising edges: two synchronizer flops, then the shift edge. The bench drives every input just after a falling edge and compares against its own model only after at least four rising edges have passed. A dedicated latency check samples the outputs after the second and after the third rising edge, and expects the old value at the first point and the shifted value at the second. The complement output is compared at every check point.

// File: rtl/gated_piso_pkg.sv
package gated_piso_pkg;
  typedef enum logic [1:0] {
    CHAIN_HOLD  = 2'd0,
    CHAIN_LOAD  = 2'd1,
    CHAIN_SHIFT = 2'd2
  } chain_op_e;
endpackage

// File: rtl/gated_piso_pin_sync.sv
module gated_piso_pin_sync #(
  parameter int  DEPTH     = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic pin_sync
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {DEPTH{RESET_VAL}};
    else     sr <= {sr[DEPTH-2:0], pin_in};
  end

  assign pin_sync = sr[DEPTH-1];
endmodule

// File: rtl/gated_piso_edge.sv
module gated_piso_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_a_s,
  input  logic pin_b_s,
  output logic fire
);
  logic gated;
  logic gated_prev;

  // NOR of the pins is the internal clock; its falling edge equals a
  // rising edge of the OR, so the OR is tracked directly.
  assign gated = pin_a_s | pin_b_s;

  always_ff @(posedge clk) begin
    if (rst) gated_prev <= 1'b1;
    else     gated_prev <= gated;
  end

  assign fire = gated & ~gated_prev;
endmodule

// File: rtl/gated_piso_chain.sv
module gated_piso_chain
  import gated_piso_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  chain_op_e         op,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic [STAGES-1:0] stage_q,
  output logic              q_last,
  output logic              q_last_n
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stage_d;

  always_comb begin
    unique case (op)
      CHAIN_LOAD:  stage_d = par_in;
      CHAIN_SHIFT: stage_d = {stage_q[LAST-1:0], ser_in};
      default:     stage_d = stage_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      q_last   <= 1'b0;
      q_last_n <= 1'b1;
    end else begin
      stage_q  <= stage_d;
      q_last   <= stage_d[LAST];
      q_last_n <= ~stage_d[LAST];
    end
  end
endmodule

// File: rtl/gated_piso_shift.sv
module gated_piso_shift
  import gated_piso_pkg::*;
#(
  parameter int STAGES     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_pin_a,
  input  logic              clk_pin_b,
  input  logic              load_n,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              q_last,
  output logic              q_last_n
);
  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pins_raw;
  logic [NUM_PINS-1:0] pins_s;
  logic                pin_a_s;
  logic                pin_b_s;
  logic                shift_fire;
  logic [STAGES-1:0]   stage_q;
  chain_op_e           op;

  assign pins_raw = {clk_pin_b, clk_pin_a};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
    gated_piso_pin_sync #(.DEPTH(SYNC_DEPTH), .RESET_VAL(1'b1)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .pin_in   (pins_raw[p]),
      .pin_sync (pins_s[p])
    );
  end

  assign pin_a_s = pins_s[0];
  assign pin_b_s = pins_s[1];

  gated_piso_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .pin_a_s (pin_a_s),
    .pin_b_s (pin_b_s),
    .fire    (shift_fire)
  );

  always_comb begin
    if (!load_n)         op = CHAIN_LOAD;
    else if (shift_fire) op = CHAIN_SHIFT;
    else                 op = CHAIN_HOLD;
  end

  gated_piso_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .stage_q  (stage_q),
    .q_last   (q_last),
    .q_last_n (q_last_n)
  );
endmodule

// File: rtl/gated_piso_shift_chk.sv
module gated_piso_shift_chk #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load_n,
  input logic              ser_in,
  input logic [STAGES-1:0] par_in,
  input logic [STAGES-1:0] stage_q,
  input logic              q_last,
  input logic              q_last_n,
  input logic              pin_a_s,
  input logic              pin_b_s,
  input logic              shift_fire
);
  localparam int LAST = STAGES - 1;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (stage_q == '0 && !q_last && q_last_n));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!load_n)) |-> (stage_q == $past(par_in)));

  assert_load_blocks_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!load_n && shift_fire)) |-> (stage_q == $past(par_in)));

  assert_inhibit_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && shift_fire) |-> $past(!pin_a_s && !pin_b_s));

  assert_shift_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(load_n && shift_fire)) |->
      (stage_q == {$past(stage_q[LAST-1:0]), $past(ser_in)}));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(load_n && !shift_fire)) |-> $stable(stage_q));

  assert_last_stage_R6: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (q_last == stage_q[LAST]));

  assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (q_last_n == ~q_last));
endmodule

bind gated_piso_shift gated_piso_shift_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_n     (load_n),
  .ser_in     (ser_in),
  .par_in     (par_in),
  .stage_q    (stage_q),
  .q_last     (q_last),
  .q_last_n   (q_last_n),
  .pin_a_s    (pin_a_s),
  .pin_b_s    (pin_b_s),
  .shift_fire (shift_fire)
);

// File: tb/gated_piso_shift_tb.sv
`timescale 1ns/1ps
module gated_piso_shift_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_pin_a = 1'b0;
  logic       clk_pin_b = 1'b0;
  logic       load_n = 1'b1;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       q_last;
  logic       q_last_n;

  int         n_checks = 0;
  int         n_fail = 0;
  int         cycles = 0;
  logic [7:0] model = 8'h00;
  logic       g_prev = 1'b1;

  always #2 clk = ~clk;

  gated_piso_shift u_dut (
    .clk       (clk),
    .rst       (rst),
    .clk_pin_a (clk_pin_a),
    .clk_pin_b (clk_pin_b),
    .load_n    (load_n),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .q_last    (q_last),
    .q_last_n  (q_last_n)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic check_out(input string req, input logic exp);
    n_checks++;
    if (q_last !== exp || q_last_n !== ~exp) begin
      n_fail++;
      $display("FAIL %s: q_last=%b q_last_n=%b expected %b/%b", req, q_last, q_last_n, exp, ~exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive both pins, let the synchronizers settle, update the model.
  task automatic set_pins(input logic a, input logic b);
    logic g_new;
    g_new = a | b;
    clk_pin_a = a;
    clk_pin_b = b;
    wait_neg(4);
    if (!load_n)                   model = par_in;
    else if (g_new && !g_prev)     model = {model[6:0], ser_in};
    g_prev = g_new;
  endtask

  task automatic do_load(input logic [7:0] v);
    par_in = v;
    load_n = 1'b0;
    wait_neg(1);
    load_n = 1'b1;
    model = v;
  endtask

  // One shift clocked on pin A (use_b=0) or pin B (use_b=1).
  task automatic pulse(input logic use_b);
    if (use_b) begin set_pins(1'b0, 1'b1); set_pins(1'b0, 1'b0); end
    else       begin set_pins(1'b1, 1'b0); set_pins(1'b0, 1'b0); end
  endtask

  initial begin
    // R1: reset with pin A high; no false shift afterwards
    clk_pin_a = 1'b1;
    ser_in = 1'b1;
    wait_neg(3);
    rst = 1'b0;
    g_prev = 1'b1;
    wait_neg(1);
    check_out("R1 reset state", 1'b0);
    wait_neg(4);
    check_out("R1 no shift with pin held after reset", 1'b0);
    ser_in = 1'b0;
    set_pins(1'b0, 1'b0);
    for (int i = 0; i < 7; i++) pulse(i[0]);
    check_out("R1 no false shift after reset", model[7]);

    // R2 and R6: exhaustive load values, each shifted out fully
    for (int v = 0; v < 256; v++) begin
      do_load(v[7:0]);
      check_out("R2 parallel load", model[7]);
      for (int s = 0; s < 8; s++) begin
        ser_in = ~v[s];
        pulse(v[s]);
        check_out("R6 shift order", model[7]);
      end
    end

    // R6: serial input travels through all stages
    for (int p = 0; p < 4; p++) begin
      logic [7:0] pat;
      pat = 8'h3C ^ (8'h55 << p);
      do_load(8'h00);
      for (int s = 0; s < 16; s++) begin
        ser_in = pat[s % 8];
        pulse(s[1]);
        check_out("R6 serial fill", model[7]);
      end
    end

    // R5: latency of exactly three rising edges, single shift per edge
    do_load(8'b1000_0000);
    ser_in = 1'b0;
    clk_pin_a = 1'b1;
    wait_neg(2);
    check_out("R5 not shifted after two edges", 1'b1);
    wait_neg(1);
    check_out("R5 shifted at third edge", 1'b0);
    model = 8'b0000_0000;
    g_prev = 1'b1;
    wait_neg(4);
    check_out("R5 exactly one shift per edge", 1'b0);
    set_pins(1'b0, 1'b0);

    // R4: with A high, B toggles do nothing; and vice versa
    do_load(8'b1010_1010);
    ser_in = 1'b1;
    set_pins(1'b1, 1'b0);
    check_out("R4 inhibit entry shift", model[7]);
    for (int i = 0; i < 4; i++) begin
      set_pins(1'b1, 1'b1);
      set_pins(1'b1, 1'b0);
      check_out("R4 pin A inhibits pin B", model[7]);
    end
    set_pins(1'b0, 1'b0);
    set_pins(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      set_pins(1'b1, 1'b1);
      set_pins(1'b0, 1'b1);
      check_out("R4 pin B inhibits pin A", model[7]);
    end
    set_pins(1'b0, 1'b0);
    for (int s = 0; s < 8; s++) begin
      ser_in = s[0];
      pulse(1'b0);
      check_out("R4 contents intact after inhibit", model[7]);
    end

    // R3: load held low while the pins toggle
    par_in = 8'b0110_1001;
    load_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ser_in = i[0];
      pulse(i[1]);
      check_out("R3 load overrides clock", model[7]);
    end
    par_in = 8'b1001_0110;
    wait_neg(1);
    model = par_in;
    check_out("R3 load follows parallel inputs", model[7]);
    load_n = 1'b1;
    for (int s = 0; s < 8; s++) begin
      ser_in = 1'b0;
      pulse(s[0]);
      check_out("R3 loaded value shifts out unchanged", model[7]);
    end

    // R7: idle cycles with no edges hold state
    do_load(8'b1100_0011);
    for (int i = 0; i < 3; i++) begin
      ser_in = ~ser_in;
      par_in = ~par_in;
      wait_neg(6);
      check_out("R7 hold", model[7]);
    end
    for (int s = 0; s < 8; s++) begin
      pulse(s[0]);
      check_out("R7 held contents, R8 complement", model[7]);
    end

    finish_run();
  end
endmodule